// File: doc/BRIEF.md
# Set-Associative Translation Buffer with Command Registers

This block holds the main translation buffer of a memory management unit. Each entry pairs a virtual page and an 8-bit address-space identifier with a frame word that holds frame number and permissions. The entries sit in a parameterised number of sets and ways. Software never addresses the storage directly. It loads two descriptor registers and an index register, then writes a command code to a command register. The descriptor registers are the tag word (identifier, present bit and virtual page) and the frame word.

The commands cover six operations. A lookup finds a tag and reports where it lives, or reports that it is absent or duplicated. A slot-selection command chooses a place for a new entry. There are two store commands, a read-back command, and a command that only tells a separate micro-translation buffer to drop its contents. The micro-buffer is told through a one-cycle pulse output. The normal store also raises this pulse, while the second store kind leaves the micro-buffer alone, so refill code can avoid needless flushes.

Every command runs in one execution cycle, following the cycle in which it is accepted. A busy flag covers that execution cycle. Software polls the flag before it reads results or issues the next access.

Top module: `tlbc_top`

## Requirements
- R1: After reset, busy and the flush pulse are low, the index register reads 0x8000_0000, and every entry is absent, so any lookup misses.
- R2: Register select 0 is the tag word, 1 the frame word, 2 the index register and 3 the command register. A write with select 3 while idle is accepted, and busy is high for exactly the next cycle. Any register or command write made while busy is ignored.
- R3: The tag word holds the identifier in bits 7:0, the present bit in bit 8 and the virtual page from bit 9 upward. The set is the low log2(SETS) bits of the virtual page. The linear index of an entry is set*WAYS+way.
- R4: Command 1 (lookup) matches identifier and virtual page against the present ways of the addressed set. On exactly one match, the index register becomes that linear index with bits 31:30 clear.
- R5: A lookup with no match loads 0x8000_0000 (lookup-error flag in bit 31) into the index register.
- R6: A lookup that matches two or more ways loads the duplicate code 0xC000_0000. Installing a duplicate raises no error.
- R7: Command 2 (slot selection) loads the linear index of the lowest-numbered absent way of the addressed set.
- R8: When every way of the set is present, slot selection returns the way held by that set's own rotating pointer. The pointer starts at way 0 after reset and advances by one on each such use. The pointers of other sets are unaffected.
- R9: Command 3 stores both descriptor words at the index and pulses the flush output high for one cycle. Command 4 stores them without a pulse.
- R10: Command 6 pulses the flush output for one cycle and leaves all entries unchanged.
- R11: Command 5 loads both descriptor registers from the entry at the index. The returned present bit shows whether the entry is valid.
- R12: Storing an all-zero tag word erases the entry, so a later lookup of its old tag misses.
- R13: While the index register holds bit 31 or bit 30 set, store and read commands change neither the entries nor the descriptor registers, and a store gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 32 | Register write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 32 | Selected register contents |
| busy | output | 1 | A command is executing this cycle |
| utlb_flush | output | 1 | One-cycle invalidate pulse to the micro-buffer |

## Verification
The embedded assertions check, on every cycle, that busy never lasts more than one cycle and that the flush pulse only ever follows an execution cycle. They also check that writes arriving during an execution cycle leave the tag register untouched, that a multiple match always becomes the duplicate code, and that slot selection picks a way the storage reports as absent when one exists. The bench scenarios cover the rest: the arithmetic of the linear index across a whole small buffer, the rotation order of the victim pointer in one set against the others, the read-back of stored words, erasure, and the refusal to store or read through an error-flagged index.

// File: rtl/tlbc_pkg.sv
// Shared encodings for the translation buffer command unit.
// Assumes a 32-bit register interface and an 8-bit address-space identifier.
package tlbc_pkg;
    localparam int DW       = 32;
    localparam int ASID_W   = 8;
    localparam int PRES_BIT = 8;
    localparam int VPN_LSB  = 9;
    localparam int ERR_BIT  = 31;
    localparam int DUP_BIT  = 30;

    localparam logic [1:0] SEL_TAG   = 2'd0;
    localparam logic [1:0] SEL_FRAME = 2'd1;
    localparam logic [1:0] SEL_INDEX = 2'd2;
    localparam logic [1:0] SEL_CMD   = 2'd3;

    localparam logic [DW-1:0] MISS_CODE = 32'h8000_0000;
    localparam logic [DW-1:0] DUP_CODE  = 32'hC000_0000;

    typedef enum logic [2:0] {
        CMD_NONE     = 3'd0,
        CMD_LOOKUP   = 3'd1,
        CMD_PICKSLOT = 3'd2,
        CMD_STORE    = 3'd3,
        CMD_STORE_NF = 3'd4,
        CMD_FETCH    = 3'd5,
        CMD_UFLUSH   = 3'd6
    } tlb_cmd_e;
endpackage

// File: rtl/tlbc_store.sv
// Entry storage: tag and frame words per entry plus a resettable valid bit.
// Assumes WAYS is a power of two so {set,way} equals set*WAYS+way.
// Provides one whole-set read port for matching and one entry port for
// read-back and writes.
module tlbc_store
    import tlbc_pkg::*;
#(
    parameter int SETS = 128,
    parameter int WAYS = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [$clog2(SETS*WAYS)-1:0]  eidx,
    input  logic [DW-1:0]                 wtag,
    input  logic [DW-1:0]                 wframe,
    output logic [DW-1:0]                 rtag,
    output logic [DW-1:0]                 rframe,
    input  logic [$clog2(SETS)-1:0]       qset,
    output logic [WAYS-1:0][DW-1:0]       set_tag,
    output logic [WAYS-1:0]               set_vld
);
    localparam int ENTRIES = SETS * WAYS;
    localparam int WAY_W   = $clog2(WAYS);

    logic [DW-1:0]      tag_mem   [ENTRIES];
    logic [DW-1:0]      frame_mem [ENTRIES];
    logic [ENTRIES-1:0] vld;

    // Valid bits: cleared by reset, follow the present bit on each store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else if (we) begin
            vld[eidx] <= wtag[PRES_BIT];
        end
    end

    // Data words: no reset needed, qualified by the valid bit.
    always_ff @(posedge clk) begin
        if (we) begin
            tag_mem[eidx]   <= wtag;
            frame_mem[eidx] <= wframe;
        end
    end

    // Entry read port with the present bit taken from the valid array.
    always_comb begin
        rtag           = tag_mem[eidx];
        rtag[PRES_BIT] = vld[eidx];
        rframe         = frame_mem[eidx];
    end

    // Whole-set read port, one slice per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        localparam logic [WAY_W-1:0] WSEL = WAY_W'(w);
        assign set_tag[w] = tag_mem[{qset, WSEL}];
        assign set_vld[w] = vld[{qset, WSEL}];
    end
endmodule

// File: rtl/tlbc_match.sv
// Compares a lookup key against the ways of one set.
// Reports the match vector, single and multiple match, the lowest matching
// way and the lowest absent way. Purely combinational.
module tlbc_match
    import tlbc_pkg::*;
#(
    parameter int WAYS  = 2,
    parameter int VPN_W = 19
) (
    input  logic [DW-1:0]             key,
    input  logic [WAYS-1:0][DW-1:0]   set_tag,
    input  logic [WAYS-1:0]           set_vld,
    output logic [WAYS-1:0]           hit_vec,
    output logic                      hit_one,
    output logic                      hit_dup,
    output logic [$clog2(WAYS)-1:0]   hit_way,
    output logic                      free_any,
    output logic [$clog2(WAYS)-1:0]   free_way
);
    localparam int WAY_W = $clog2(WAYS);

    // Per-way tag compare on identifier and virtual page.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = set_vld[w]
            && (set_tag[w][ASID_W-1:0] == key[ASID_W-1:0])
            && (set_tag[w][VPN_LSB +: VPN_W] == key[VPN_LSB +: VPN_W]);
    end

    // Count matches and locate the lowest matching way.
    always_comb begin
        int n;
        n       = 0;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                n       = n + 1;
                hit_way = WAY_W'(w);
            end
        end
        hit_one = (n == 1);
        hit_dup = (n > 1);
    end

    // Locate the lowest absent way.
    always_comb begin
        free_any = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!set_vld[w]) begin
                free_any = 1'b1;
                free_way = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/tlbc_rr.sv
// Per-set rotating victim pointers, used when a set has no absent way.
// Assumes WAYS is a power of two so the pointer wraps naturally.
module tlbc_rr #(
    parameter int SETS = 128,
    parameter int WAYS = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [$clog2(SETS)-1:0]   set,
    input  logic                      adv,
    output logic [$clog2(WAYS)-1:0]   way
);
    localparam int WAY_W = $clog2(WAYS);

    logic [WAY_W-1:0] ptr [SETS];

    assign way = ptr[set];

    // Pointer update: reset to way 0, step the addressed set on each use.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) ptr[s] <= '0;
        end else if (adv) begin
            ptr[set] <= ptr[set] + 1'b1;
        end
    end
endmodule

// File: rtl/tlbc_top.sv
// Translation buffer command unit: descriptor, index and command registers
// around set-associative entry storage. Accepts a command only when idle,
// executes it in the following cycle (busy high) and pulses the micro-buffer
// flush output one cycle later for flushing commands.
// Assumes SETS and WAYS are powers of two, WAYS >= 2, SETS <= 2**VPN_W.
module tlbc_top
    import tlbc_pkg::*;
#(
    parameter int SETS  = 128,
    parameter int WAYS  = 2,
    parameter int VPN_W = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [31:0]   wr_data,
    input  logic [1:0]    rd_sel,
    output logic [31:0]   rd_data,
    output logic          busy,
    output logic          utlb_flush
);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int IDX_W = SET_W + WAY_W;

    logic [DW-1:0] tag_q, frame_q, idx_q;
    logic          busy_q, flush_q;
    tlb_cmd_e      cmd_q;

    logic                   sw_ok, idx_ok, st_we, rr_adv;
    logic [SET_W-1:0]       key_set;
    logic [IDX_W-1:0]       cur_idx;
    logic [DW-1:0]          e_tag, e_frame;
    logic [WAYS-1:0][DW-1:0] s_tag;
    logic [WAYS-1:0]        s_vld, hit_vec;
    logic                   hit_one, hit_dup, free_any;
    logic [WAY_W-1:0]       hit_way, free_way, rr_way;

    assign sw_ok   = wr_en && !busy_q;
    assign key_set = tag_q[VPN_LSB +: SET_W];
    assign cur_idx = idx_q[IDX_W-1:0];
    assign idx_ok  = !idx_q[ERR_BIT] && !idx_q[DUP_BIT];
    assign st_we   = busy_q && idx_ok
                     && (cmd_q == CMD_STORE || cmd_q == CMD_STORE_NF);
    assign rr_adv  = busy_q && (cmd_q == CMD_PICKSLOT) && !free_any;

    tlbc_store #(.SETS(SETS), .WAYS(WAYS)) i_store (
        .clk(clk), .rst_n(rst_n), .we(st_we), .eidx(cur_idx),
        .wtag(tag_q), .wframe(frame_q), .rtag(e_tag), .rframe(e_frame),
        .qset(key_set), .set_tag(s_tag), .set_vld(s_vld)
    );

    tlbc_match #(.WAYS(WAYS), .VPN_W(VPN_W)) i_match (
        .key(tag_q), .set_tag(s_tag), .set_vld(s_vld), .hit_vec(hit_vec),
        .hit_one(hit_one), .hit_dup(hit_dup), .hit_way(hit_way),
        .free_any(free_any), .free_way(free_way)
    );

    tlbc_rr #(.SETS(SETS), .WAYS(WAYS)) i_rr (
        .clk(clk), .rst_n(rst_n), .set(key_set), .adv(rr_adv), .way(rr_way)
    );

    // Index value built from a set and a way, error flags clear.
    function automatic logic [DW-1:0] mk_idx(logic [SET_W-1:0] s, logic [WAY_W-1:0] w);
        logic [DW-1:0] v;
        v = '0;
        v[IDX_W-1:0] = {s, w};
        return v;
    endfunction

    // Software view of the index register: flags and index field only.
    function automatic logic [DW-1:0] mask_idx(logic [DW-1:0] d);
        logic [DW-1:0] v;
        v = '0;
        v[ERR_BIT] = d[ERR_BIT];
        v[DUP_BIT] = d[DUP_BIT];
        v[IDX_W-1:0] = d[IDX_W-1:0];
        return v;
    endfunction

    // Register writes, command acceptance and one-cycle command execution.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q   <= '0;
            frame_q <= '0;
            idx_q   <= MISS_CODE;
            busy_q  <= 1'b0;
            flush_q <= 1'b0;
            cmd_q   <= CMD_NONE;
        end else begin
            flush_q <= 1'b0;
            busy_q  <= sw_ok && (wr_sel == SEL_CMD);
            if (sw_ok) begin
                case (wr_sel)
                    SEL_TAG:   tag_q   <= wr_data;
                    SEL_FRAME: frame_q <= wr_data;
                    SEL_INDEX: idx_q   <= mask_idx(wr_data);
                    default:   cmd_q   <= tlb_cmd_e'(wr_data[2:0]);
                endcase
            end
            if (busy_q) begin
                case (cmd_q)
                    CMD_LOOKUP: begin
                        if (hit_dup)      idx_q <= DUP_CODE;
                        else if (hit_one) idx_q <= mk_idx(key_set, hit_way);
                        else              idx_q <= MISS_CODE;
                    end
                    CMD_PICKSLOT: begin
                        idx_q <= mk_idx(key_set, free_any ? free_way : rr_way);
                    end
                    CMD_STORE: flush_q <= idx_ok;
                    CMD_FETCH: begin
                        if (idx_ok) begin
                            tag_q   <= e_tag;
                            frame_q <= e_frame;
                        end
                    end
                    CMD_UFLUSH: flush_q <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // Read multiplexer over the four registers.
    always_comb begin
        case (rd_sel)
            SEL_TAG:   rd_data = tag_q;
            SEL_FRAME: rd_data = frame_q;
            SEL_INDEX: rd_data = idx_q;
            default:   rd_data = {29'd0, cmd_q};
        endcase
    end

    assign busy       = busy_q;
    assign utlb_flush = flush_q;

    // R2: execution never lasts beyond one cycle.
    p_busy_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> !busy_q);

    // R2: a tag write during execution is dropped unless a fetch is running.
    p_ignore_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && wr_en && cmd_q != CMD_FETCH) |=> $stable(tag_q));

    // R9 / R10: the flush pulse only follows an execution cycle.
    p_flush_after_exec_r10: assert property (@(posedge clk) disable iff (!rst_n)
        utlb_flush |-> $past(busy_q));

    // R6: a multiple match always reports the duplicate code.
    p_dup_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cmd_q == CMD_LOOKUP && $countones(hit_vec) > 1) |=> idx_q == DUP_CODE);

    // R7: slot selection with an absent way picks a way storage reports absent.
    p_pick_absent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cmd_q == CMD_PICKSLOT && free_any) |-> !s_vld[free_way]);
endmodule

// File: tb/test_tlbc_top.sv
// Sweeps a 4-set by 4-way configuration; expected values are computed from
// the linear index rule set*WAYS+way.
module test_tlbc_top;
    localparam int SETS = 4;
    localparam int WAYS = 4;
    localparam int VPN_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic        busy, utlb_flush;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    tlbc_top #(.SETS(SETS), .WAYS(WAYS), .VPN_W(VPN_W)) i_tlbc_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .busy(busy), .utlb_flush(utlb_flush)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_tag(int vpn, int asid);
        return (32'(vpn) << 9) | 32'h100 | 32'(asid & 8'hff);
    endfunction

    task automatic put(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Issue a command, wait for execution, return the flush level seen after.
    task automatic run(input int c, output logic fl);
        put(2'd3, 32'(c));
        @(negedge clk);
        fl = utlb_flush;
    endtask

    task automatic peek(input logic [1:0] sel, output logic [31:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic        fl;
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        peek(2'd2, v); check("R1 index after reset", v, 32'h8000_0000);
        check("R1 busy after reset", {31'd0, busy}, 32'd0);
        check("R1 flush after reset", {31'd0, utlb_flush}, 32'd0);
        put(2'd0, mk_tag(5, 8'h33));
        run(1, fl); peek(2'd2, v); check("R1 R5 lookup on empty", v, 32'h8000_0000);

        // R3 R7 R9: fill every entry through slot selection then store
        for (int s = 0; s < SETS; s++) begin
            for (int k = 0; k < WAYS; k++) begin
                put(2'd0, mk_tag(s + SETS * k, 8'h20 + s * WAYS + k));
                put(2'd1, 32'hA000 + 32'(s * 16 + k));
                run(2, fl); peek(2'd2, v);
                check("R7 R3 slot selection lowest absent", v, 32'(s * WAYS + k));
                run(((s + k) % 2 == 0) ? 3 : 4, fl);
                check((((s + k) % 2) == 0) ? "R9 store pulses flush" : "R9 no-flush store",
                      {31'd0, fl}, (((s + k) % 2) == 0) ? 32'd1 : 32'd0);
            end
        end

        // R4 R3: lookups land on the arithmetic index
        for (int s = 0; s < SETS; s++) begin
            for (int k = 0; k < WAYS; k++) begin
                put(2'd0, mk_tag(s + SETS * k, 8'h20 + s * WAYS + k));
                run(1, fl); peek(2'd2, v);
                check("R4 single hit index", v, 32'(s * WAYS + k));
            end
        end

        // R11: read back each entry
        for (int i = 0; i < SETS * WAYS; i++) begin
            put(2'd2, 32'(i));
            run(5, fl);
            peek(2'd0, v);
            check("R11 fetched tag", v, mk_tag(i / WAYS + SETS * (i % WAYS), 8'h20 + i));
            peek(2'd1, v);
            check("R11 fetched frame", v, 32'hA000 + 32'((i / WAYS) * 16 + i % WAYS));
        end

        // R8: full set 1 rotates 0,1,2; set 2 still starts at way 0
        for (int r = 0; r < 3; r++) begin
            put(2'd0, mk_tag(1 + SETS * 7, 8'h01));
            run(2, fl); peek(2'd2, v);
            check("R8 rotating victim set 1", v, 32'(1 * WAYS + r));
        end
        put(2'd0, mk_tag(2 + SETS * 7, 8'h01));
        run(2, fl); peek(2'd2, v);
        check("R8 other set pointer untouched", v, 32'(2 * WAYS));

        // R5: known page under another identifier misses
        put(2'd0, mk_tag(3, 8'h99));
        run(1, fl); peek(2'd2, v);
        check("R5 identifier mismatch misses", v, 32'h8000_0000);

        // R6: copy the tag of index 1 into index 0
        put(2'd2, 32'd0);
        put(2'd0, mk_tag(0 + SETS * 1, 8'h21));
        run(4, fl);
        check("R6 duplicate install no pulse", {31'd0, fl}, 32'd0);
        run(1, fl); peek(2'd2, v);
        check("R6 duplicate code", v, 32'hC000_0000);

        // R12: erase index 5 then its old tag misses, and slot selection finds it
        put(2'd2, 32'd5);
        put(2'd0, 32'd0);
        put(2'd1, 32'd0);
        run(3, fl);
        put(2'd0, mk_tag(1 + SETS * 1, 8'h25));
        run(1, fl); peek(2'd2, v);
        check("R12 erased entry misses", v, 32'h8000_0000);
        run(2, fl); peek(2'd2, v);
        check("R7 slot selection finds erased way", v, 32'd5);

        // R10: flush command pulses and leaves index 6 intact
        run(6, fl);
        check("R10 flush command pulse", {31'd0, fl}, 32'd1);
        @(negedge clk);
        check("R10 pulse lasts one cycle", {31'd0, utlb_flush}, 32'd0);
        put(2'd2, 32'd6);
        run(5, fl); peek(2'd0, v);
        check("R10 entry unchanged", v, mk_tag(1 + SETS * 2, 8'h26));

        // R13: error-flagged index blocks store and read
        put(2'd0, mk_tag(3 + SETS * 9, 8'h44));
        run(1, fl);
        run(3, fl);
        check("R13 no pulse on blocked store", {31'd0, fl}, 32'd0);
        run(1, fl); peek(2'd2, v);
        check("R13 blocked store left no entry", v, 32'h8000_0000);
        run(5, fl); peek(2'd0, v);
        check("R13 blocked read keeps tag", v, mk_tag(3 + SETS * 9, 8'h44));

        // R2: busy window and a write made during it
        put(2'd3, 32'd6);
        check("R2 busy after accept", {31'd0, busy}, 32'd1);
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'hDEAD_BEEF;
        @(negedge clk);
        wr_en = 1'b0;
        check("R2 busy drops", {31'd0, busy}, 32'd0);
        peek(2'd0, v);
        check("R2 write during busy ignored", v, mk_tag(3 + SETS * 9, 8'h44));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule